// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double data rate SDRAM and drives its command bus from reset until the memory is ready for normal traffic. It comes out of reset with clock enable held low and waits a programmable power-up interval, counted in clock cycles. It then raises clock enable with a no-op and issues a fixed series of commands. The series precharges every bank. It turns the DLL on through the extended mode register, then resets the DLL through the main mode register and waits for it to lock. After a second precharge of every bank it runs a programmable number of auto refreshes, and it ends by rewriting the main mode register with the DLL reset bit cleared.

Every wait between commands is filled with no-op commands. Each wait length is a parameter, given as the spacing in clocks between one command and the next. Burst length, burst type, CAS latency and output drive strength come in on configuration inputs. They are placed into the mode register words when those words are issued. Once the last mode register delay has run out, a done flag rises and stays high, and the bus stays on no-op.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and for PWRUP_CYC cycles after its release, cke is 0, the command is no-op and init_done is 0. Command pins {cs_n,ras_n,cas_n,we_n}: no-op 0111, precharge 0010, auto refresh 0001, mode register write 0000.
- R2: In the cycle after the power-up interval a no-op is issued with cke 1, and cke stays 1 until the next reset.
- R3: In the cycle after that no-op a precharge is issued with addr[8]=1 (all banks) and every other address bit 0.
- R4: TRP_CYC clocks after the first precharge, the extended mode register is written: ba=2'b01, addr[0]=0 (DLL on), addr[1]=cfg_half_drive (0 full, 1 half strength), all other address bits 0.
- R5: TMRD_CYC clocks after that, the main mode register is written with ba=2'b00, addr[2:0]=cfg_burst_len, addr[3]=cfg_burst_type, addr[6:4]=cfg_cas_lat, addr[7]=0, addr[8]=1 (DLL reset) and all higher bits 0.
- R6: The next command is a precharge of all banks (addr[8]=1). It comes exactly DLL_LOCK_CYC clocks after the DLL reset write, with only no-op in between.
- R7: NUM_REF auto refresh commands follow. The first comes TRP_CYC clocks after the second precharge, and each later one comes TRFC_CYC clocks after the one before. Address and bank bits are 0.
- R8: TRFC_CYC clocks after the last refresh, the main mode register is written again with the same fields as R5 but addr[8]=0.
- R9: init_done rises exactly TMRD_CYC clocks after the final mode register write. It then stays 1 with a no-op on the bus until reset.
- R10: Every cycle between two commands carries a no-op (cs_n=0, ras_n=cas_n=we_n=1), and no two commands are issued in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, also the memory clock |
| rst_n | input | 1 | Active-low synchronous reset, restarts the sequence |
| cfg_cas_lat | input | 3 | CAS latency code for mode register bits 6:4 (011 = 3) |
| cfg_burst_type | input | 1 | Burst type for mode register bit 3 (0 sequential, 1 interleave) |
| cfg_burst_len | input | 3 | Burst length code for mode register bits 2:0 (001=2, 010=4, 011=8) |
| cfg_half_drive | input | 1 | Output drive strength for extended register bit 1 (1 = half) |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, selects which mode register is written |
| addr | output | ADDR_W | Address bus: all-bank flag or mode register word |
| init_done | output | 1 | High once normal operation may begin |

## Verification
The assertions check, on every cycle, the rules that hold cycle by cycle. A low cke means a no-op and no done flag. Clock enable and done never fall outside reset. A precharge always carries the all-bank flag. Mode register writes never select bank bit 1 or the test mode bit, and the extended write carries the DLL-on bit and the requested drive strength. A command is always followed by a no-op. The exact spacing between commands, the order of the series, the number of refreshes and the way the configuration fields land in the mode words can only be shown by the bench. It does this by predicting, for every cycle after reset, the full bus value from the timing parameters and comparing it across a sweep of all configuration combinations, including a reset taken during the DLL lock wait.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // Command pin order: {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } ddr_cmd_e;

   typedef enum logic [3:0] {
      ST_PWR,
      ST_CKE,
      ST_PRE1,
      ST_WRP1,
      ST_EMRS,
      ST_WMRD1,
      ST_MRSR,
      ST_WDLL,
      ST_PRE2,
      ST_WRP2,
      ST_REF,
      ST_WRFC,
      ST_MRSF,
      ST_WMRD2,
      ST_DONE
   } init_st_e;

   localparam int AP_BIT = 8;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R10
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);

   // R10
   tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!expired && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr_init_mode_word.sv
module ddr_init_mode_word #(
   parameter int ADDR_W = 11
) (
   input  logic              ext_sel,
   input  logic              dll_rst,
   input  logic [2:0]        cas_lat,
   input  logic              burst_type,
   input  logic [2:0]        burst_len,
   input  logic              half_drive,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr
);

   localparam int FIELD_W = 9;

   logic [FIELD_W-1:0] field;

   always_comb begin
      if (ext_sel)
         field = {7'b0, half_drive, 1'b0};
      else
         field = {dll_rst, 1'b0, cas_lat, burst_type, burst_len};
      ba = ext_sel ? 2'b01 : 2'b00;
   end

   generate
      if (ADDR_W > FIELD_W) begin : g_pad
         assign addr = {{(ADDR_W-FIELD_W){1'b0}}, field};
      end else begin : g_exact
         assign addr = field;
      end
   endgenerate

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
   import ddr_init_pkg::*;
(
   input  ddr_cmd_e cmd,
   output logic     cs_n,
   output logic     ras_n,
   output logic     cas_n,
   output logic     we_n
);

   assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int PWRUP_CYC    = 40000,
   parameter int DLL_LOCK_CYC = 200,
   parameter int TRP_CYC      = 3,
   parameter int TMRD_CYC     = 2,
   parameter int TRFC_CYC     = 14,
   parameter int NUM_REF      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_cas_lat,
   input  logic              cfg_burst_type,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_half_drive,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   localparam int DLL_GAP = max_of(DLL_LOCK_CYC, TMRD_CYC);
   localparam int MAX_T   = max_of(max_of(PWRUP_CYC, DLL_GAP), max_of(TRFC_CYC, TRP_CYC));
   localparam int TMR_W   = $clog2(MAX_T + 1);
   localparam int REF_W   = $clog2(NUM_REF + 1);

   localparam logic [TMR_W-1:0] RP_LD  = TMR_W'(TRP_CYC - 2);
   localparam logic [TMR_W-1:0] MRD_LD = TMR_W'(TMRD_CYC - 2);
   localparam logic [TMR_W-1:0] DLL_LD = TMR_W'(DLL_GAP - 2);
   localparam logic [TMR_W-1:0] RFC_LD = TMR_W'(TRFC_CYC - 2);
   localparam logic [ADDR_W-1:0] AP_ADDR = ADDR_W'(1) << AP_BIT;

   generate
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ADDR_W must be at least 9");
      end
      if (PWRUP_CYC < 1) begin : g_bad_pwr
         $error("PWRUP_CYC must be at least 1");
      end
      if (DLL_LOCK_CYC < 200) begin : g_bad_dll
         $error("DLL_LOCK_CYC must be at least 200");
      end
      if (TRP_CYC < 2 || TMRD_CYC < 2 || TRFC_CYC < 2) begin : g_bad_gap
         $error("command spacings must be at least 2");
      end
      if (NUM_REF < 2) begin : g_bad_ref
         $error("NUM_REF must be at least 2");
      end
   endgenerate

   init_st_e         st_q, st_d;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_exp;
   logic [REF_W-1:0] ref_cnt_q;
   logic             ref_inc;
   ddr_cmd_e         cmd;
   logic             mw_ext;
   logic             mw_rst;
   logic [1:0]       mw_ba;
   logic [ADDR_W-1:0] mw_addr;

   ddr_init_timer #(
      .CNT_W   (TMR_W),
      .RST_VAL (PWRUP_CYC - 1)
   ) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_PWR;
         ref_cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (ref_inc)
            ref_cnt_q <= ref_cnt_q + 1'b1;
      end
   end

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ref_inc  = 1'b0;
      case (st_q)
         ST_PWR:   if (tmr_exp) st_d = ST_CKE;
         ST_CKE:   st_d = ST_PRE1;
         ST_PRE1:  begin st_d = ST_WRP1;  tmr_load = 1'b1; tmr_val = RP_LD;  end
         ST_WRP1:  if (tmr_exp) st_d = ST_EMRS;
         ST_EMRS:  begin st_d = ST_WMRD1; tmr_load = 1'b1; tmr_val = MRD_LD; end
         ST_WMRD1: if (tmr_exp) st_d = ST_MRSR;
         ST_MRSR:  begin st_d = ST_WDLL;  tmr_load = 1'b1; tmr_val = DLL_LD; end
         ST_WDLL:  if (tmr_exp) st_d = ST_PRE2;
         ST_PRE2:  begin st_d = ST_WRP2;  tmr_load = 1'b1; tmr_val = RP_LD;  end
         ST_WRP2:  if (tmr_exp) st_d = ST_REF;
         ST_REF:   begin
            st_d     = ST_WRFC;
            tmr_load = 1'b1;
            tmr_val  = RFC_LD;
            ref_inc  = 1'b1;
         end
         ST_WRFC:  if (tmr_exp) st_d = (ref_cnt_q == REF_W'(NUM_REF)) ? ST_MRSF : ST_REF;
         ST_MRSF:  begin st_d = ST_WMRD2; tmr_load = 1'b1; tmr_val = MRD_LD; end
         ST_WMRD2: if (tmr_exp) st_d = ST_DONE;
         ST_DONE:  st_d = ST_DONE;
         default:  st_d = ST_PWR;
      endcase
   end

   always_comb begin
      mw_ext = (st_q == ST_EMRS);
      mw_rst = (st_q == ST_MRSR);
      case (st_q)
         ST_PRE1, ST_PRE2:         cmd = CMD_PRE;
         ST_EMRS, ST_MRSR, ST_MRSF: cmd = CMD_MRS;
         ST_REF:                   cmd = CMD_REF;
         default:                  cmd = CMD_NOP;
      endcase
   end

   ddr_init_mode_word #(
      .ADDR_W (ADDR_W)
   ) mw_i (
      .ext_sel    (mw_ext),
      .dll_rst    (mw_rst),
      .cas_lat    (cfg_cas_lat),
      .burst_type (cfg_burst_type),
      .burst_len  (cfg_burst_len),
      .half_drive (cfg_half_drive),
      .ba         (mw_ba),
      .addr       (mw_addr)
   );

   ddr_init_cmd_enc enc_i (
      .cmd   (cmd),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n)
   );

   always_comb begin
      case (cmd)
         CMD_PRE: begin addr = AP_ADDR; ba = 2'b00; end
         CMD_MRS: begin addr = mw_addr; ba = mw_ba; end
         default: begin addr = '0;      ba = 2'b00; end
      endcase
   end

   assign cke       = (st_q != ST_PWR);
   assign init_done = (st_q == ST_DONE);

   logic [3:0] pin_cmd;
   assign pin_cmd = {cs_n, ras_n, cas_n, we_n};

   // R1
   pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (pin_cmd == CMD_NOP && !init_done));

   // R2
   cke_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   // R3
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd == CMD_PRE) |-> addr[AP_BIT]);

   // R4
   emrs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd == CMD_MRS && ba == 2'b01) |-> (!addr[0] && addr[1] == cfg_half_drive));

   // R5
   mrs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd == CMD_MRS) |-> (!ba[1] && !addr[7]));

   // R7
   ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MRSF) |-> (ref_cnt_q == REF_W'(NUM_REF)));

   // R9
   done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> (init_done && pin_cmd == CMD_NOP));

   // R10
   cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd != CMD_NOP) |=> (pin_cmd == CMD_NOP));

endmodule

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W  = 11;
   localparam int P_PWR   = 20;
   localparam int P_DLL   = 200;
   localparam int P_RP    = 3;
   localparam int P_MRD   = 2;
   localparam int P_RFC   = 7;
   localparam int P_NREF  = 3;

   localparam int T_PRE1  = P_PWR + 1;
   localparam int T_EMRS  = T_PRE1 + P_RP;
   localparam int T_MRS1  = T_EMRS + P_MRD;
   localparam int T_PRE2  = T_MRS1 + P_DLL;
   localparam int T_REF0  = T_PRE2 + P_RP;
   localparam int T_MRS2  = T_REF0 + P_NREF * P_RFC;
   localparam int T_DONE  = T_MRS2 + P_MRD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] cfg_cas_lat = 3'b011;
   logic cfg_burst_type = 1'b0;
   logic [2:0] cfg_burst_len = 3'b001;
   logic cfg_half_drive = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [1:0] ba;
   logic [ADDR_W-1:0] addr;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr_init_seq #(
      .ADDR_W       (ADDR_W),
      .PWRUP_CYC    (P_PWR),
      .DLL_LOCK_CYC (P_DLL),
      .TRP_CYC      (P_RP),
      .TMRD_CYC     (P_MRD),
      .TRFC_CYC     (P_RFC),
      .NUM_REF      (P_NREF)
   ) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_cas_lat    (cfg_cas_lat),
      .cfg_burst_type (cfg_burst_type),
      .cfg_burst_len  (cfg_burst_len),
      .cfg_half_drive (cfg_half_drive),
      .cke            (cke),
      .cs_n           (cs_n),
      .ras_n          (ras_n),
      .cas_n          (cas_n),
      .we_n           (we_n),
      .ba             (ba),
      .addr           (addr),
      .init_done      (init_done)
   );

   // bus word {cke, done, cs_n, ras_n, cas_n, we_n, ba, addr}
   function automatic logic [18:0] bus_word(input logic k_cke, input logic k_done,
                                            input logic [3:0] k_cmd, input logic [1:0] k_ba,
                                            input int k_addr);
      return {k_cke, k_done, k_cmd, k_ba, ADDR_W'(k_addr)};
   endfunction

   function automatic int mrs_word(input bit dll_reset);
      return int'(cfg_burst_len) + int'(cfg_burst_type) * 8 + int'(cfg_cas_lat) * 16
             + (dll_reset ? 256 : 0);
   endfunction

   task automatic expect_at(input int k, output logic [18:0] w, output string tag);
      w   = bus_word(1'b1, 1'b0, 4'b0111, 2'b00, 0);
      tag = "R10";
      if (k < P_PWR) begin
         w = bus_word(1'b0, 1'b0, 4'b0111, 2'b00, 0); tag = "R1";
      end else if (k == P_PWR) begin
         tag = "R2";
      end else if (k == T_PRE1) begin
         w = bus_word(1'b1, 1'b0, 4'b0010, 2'b00, 256); tag = "R3";
      end else if (k == T_EMRS) begin
         w = bus_word(1'b1, 1'b0, 4'b0000, 2'b01, int'(cfg_half_drive) * 2); tag = "R4";
      end else if (k == T_MRS1) begin
         w = bus_word(1'b1, 1'b0, 4'b0000, 2'b00, mrs_word(1'b1)); tag = "R5";
      end else if (k > T_MRS1 && k < T_PRE2) begin
         tag = "R6";
      end else if (k == T_PRE2) begin
         w = bus_word(1'b1, 1'b0, 4'b0010, 2'b00, 256); tag = "R6";
      end else if (k >= T_REF0 && k < T_MRS2) begin
         tag = "R7";
         if ((k - T_REF0) % P_RFC == 0)
            w = bus_word(1'b1, 1'b0, 4'b0001, 2'b00, 0);
      end else if (k == T_MRS2) begin
         w = bus_word(1'b1, 1'b0, 4'b0000, 2'b00, mrs_word(1'b0)); tag = "R8";
      end else if (k >= T_DONE) begin
         w = bus_word(1'b1, 1'b1, 4'b0111, 2'b00, 0); tag = "R9";
      end
   endtask

   task automatic check(input string tag, input int k, input logic [18:0] act,
                        input logic [18:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, k, act, exp);
      end
   endtask

   function automatic logic [18:0] sample_bus();
      return {cke, init_done, cs_n, ras_n, cas_n, we_n, ba, addr};
   endfunction

   // Runs one sequence; abort_at > 0 takes reset at that cycle instead of finishing.
   task automatic run_seq(input int abort_at);
      logic [18:0] w;
      string tag;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", -1, sample_bus(), bus_word(1'b0, 1'b0, 4'b0111, 2'b00, 0));
      rst_n = 1'b1;
      for (int k = 0; k <= T_DONE + 4; k++) begin
         if (abort_at > 0 && k == abort_at) begin
            rst_n = 1'b0;
            @(negedge clk);
            // R1: reset taken mid-sequence drops cke and done
            check("R1", k, sample_bus(), bus_word(1'b0, 1'b0, 4'b0111, 2'b00, 0));
            return;
         end
         expect_at(k, w, tag);
         check(tag, k, sample_bus(), w);
         @(negedge clk);
      end
   endtask

   initial begin
      @(negedge clk);
      for (int cl = 2; cl <= 3; cl++) begin
         for (int bl = 1; bl <= 3; bl++) begin
            for (int bt = 0; bt <= 1; bt++) begin
               for (int hd = 0; hd <= 1; hd++) begin
                  cfg_cas_lat    = 3'(cl);
                  cfg_burst_len  = 3'(bl);
                  cfg_burst_type = 1'(bt);
                  cfg_half_drive = 1'(hd);
                  run_seq(0);
               end
            end
         end
      end
      // reset during the DLL lock wait (R6 window), then a clean rerun
      run_seq(T_MRS1 + 50);
      run_seq(0);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         fails++;
         checks++;
         $display("FAIL R9 watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule